// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two up-counting timer/counters for a small control processor. Each counter has a low and a high byte register. A machine tick is made internally, once every twelve clocks. Each counter advances either on that tick (timer function) or on a falling edge of its external count pin (counter function). A run bit and an optional gate pin enable the counter.

A 4-bit configuration nibble per counter picks the gating, the source and one of four layouts: a 13-bit prescaled counter, a full 16-bit counter, an 8-bit counter with automatic reload, or a split layout. In the split layout counter 0's two bytes run as separate 8-bit counters, and the high byte takes over counter 1's run bit and flag. Software reaches every register through one write port and one combinational read port. Overflow flags drive the interrupt logic, and one-clock overflow pulses go to a serial baud generator.

Top module: `tmr_pair`

## Requirements
- R1: After reset every count byte, the configuration byte, the run bits, the flags and both overflow pulses are 0.
- R2: A machine tick occurs on the 12th rising edge after reset is released and on every 12th edge after that. In timer function an enabled counter advances by one on each tick.
- R3: In counter function the pin is sampled on each tick. The counter advances on a tick whose sample is 0 when the previous tick's sample was 1. The sample holds 0 after reset.
- R4: A counter is enabled when its run bit is 1 and either its gate bit is 0 or its gate pin is 1.
- R5: Layout 0 (mode code 0) counts through 13 bits: bits 4..0 of the low byte, then the whole high byte. Low-byte bits 7..5 keep their value. A rollover from all ones sets the flag.
- R6: Layout 1 (mode code 1) counts through 16 bits. A rollover from FFFFh to 0000h sets the flag and counting goes on.
- R7: Layout 2 (mode code 2) counts in the low byte only. On rollover the low byte is loaded from the high byte and the flag is set. The high byte does not change.
- R8: With counter 0 in mode code 3, its low byte is an 8-bit counter under counter 0's controls. Its high byte counts ticks while run bit 1 is set, and its rollover sets flag 1. Counter 1 then counts as if its run bit were 1 (its gate still applies). Counter 1's own rollover appears only on t1_ovf_o and does not set flag 1.
- R9: Counter 1 in mode code 3 holds its count.
- R10: Clearing and then setting a run bit leaves the count bytes unchanged, and counting resumes from them.
- R11: A write to a byte that a stepping counter spans wins over the step, and no flag is set from that step. In the split layout each byte is a separate counter. A control write wins over a flag set in the same clock.
- R12: Select codes are: 0 low byte 0, 1 low byte 1, 2 high byte 0, 3 high byte 1, 4 configuration, 5 control. In the configuration byte, counter 1 uses bits 7..4 and counter 0 uses bits 3..0, each ordered gate, counter select, mode[1], mode[0]. Control bit 0 is run 0, bit 1 is run 1, bit 2 is flag 0 and bit 3 is flag 1. A write takes effect at the clock edge, and rd_data_o shows the selected register combinationally.
- R13: Each overflow pulse is high for one clock, in the same clock in which the matching flag first reads 1. t1_ovf_o follows counter 1's own rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write select code |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 3 | Read select code |
| rd_data_o | output | 8 | Selected register value |
| cnt_pin_i | input | 2 | External count pins, bit n for counter n |
| gate_pin_i | input | 2 | Gate pins, bit n for counter n |
| tf0_o | output | 1 | Flag 0 |
| tf1_o | output | 1 | Flag 1 |
| t0_ovf_o | output | 1 | One-clock pulse, counter 0 overflow |
| t1_ovf_o | output | 1 | One-clock pulse, counter 1 overflow |

## Verification
A write sampled at a rising edge is visible on rd_data_o from that edge on. A count step lands on the edge where the internal tick is high, and its flag and overflow pulse appear at that same edge. A pin edge needs the tick edge after the low sample. The bench steps a reference model at every rising edge from the same inputs. It compares one rotating register and all four flag and pulse outputs 2 ns after each falling edge, so every result is checked in the clock it is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    SEL_TL0  = 3'd0,
    SEL_TL1  = 3'd1,
    SEL_TH0  = 3'd2,
    SEL_TH1  = 3'd3,
    SEL_CFG  = 3'd4,
    SEL_CTRL = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    MD_13B    = 2'd0,
    MD_16B    = 2'd1,
    MD_RELOAD = 2'd2,
    MD_SPLIT  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      cnt_sel;
    tmr_mode_e mode;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_pin_sampler.sv
module tmr_pin_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic fall_o
);
  logic samp_q;

  // high on the previous tick, low on this one
  assign fall_o = tick_i & samp_q & ~pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     samp_q <= 1'b0;
    else if (tick_i) samp_q <= pin_i;
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PRE_W     = 5,
  parameter bit          HAS_SPLIT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr_mode_e         mode_i,
  input  logic              step_i,
  input  logic              hi_step_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              hi_ovf_o
);
  logic [DATA_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic              split;

  assign split = HAS_SPLIT && (mode_i == MD_SPLIT);

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_o    = 1'b0;
    hi_ovf_o = 1'b0;
    unique case (mode_i)
      MD_13B: if (step_i) begin
        if (&lo_q[PRE_W-1:0]) begin
          lo_d[PRE_W-1:0] = '0;
          hi_d            = hi_q + 1'b1;
          ovf_o           = &hi_q;
        end else begin
          lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
        end
      end
      MD_16B: if (step_i) begin
        {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
        ovf_o        = &{hi_q, lo_q};
      end
      MD_RELOAD: if (step_i) begin
        if (&lo_q) begin
          lo_d  = hi_q;
          ovf_o = 1'b1;
        end else begin
          lo_d = lo_q + 1'b1;
        end
      end
      MD_SPLIT: if (HAS_SPLIT) begin
        if (step_i) begin
          lo_d  = lo_q + 1'b1;
          ovf_o = &lo_q;
        end
        if (hi_step_i) begin
          hi_d     = hi_q + 1'b1;
          hi_ovf_o = &hi_q;
        end
      end
    endcase
    // software write beats the step that shares the byte
    if (split) begin
      if (wr_lo_i) begin
        lo_d  = wr_data_i;
        ovf_o = 1'b0;
      end
      if (wr_hi_i) begin
        hi_d     = wr_data_i;
        hi_ovf_o = 1'b0;
      end
    end else if (wr_lo_i || wr_hi_i) begin
      lo_d  = wr_lo_i ? wr_data_i : lo_q;
      hi_d  = wr_hi_i ? wr_data_i : hi_q;
      ovf_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PRE_W   = 5,
  parameter int unsigned TICK_DIV = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [1:0]        cnt_pin_i,
  input  logic [1:0]        gate_pin_i,
  output logic              tf0_o,
  output logic              tf1_o,
  output logic              t0_ovf_o,
  output logic              t1_ovf_o
);
  localparam int unsigned NT = 2;

  tmr_cfg_t          cfg_q [NT];
  logic [NT-1:0]     run_q, flag_q, pulse_q;
  logic [NT-1:0]     ev, en, step, ovf, hi_ovf;
  logic [NT-1:0]     wr_lo, wr_hi, run_eff, set;
  logic [DATA_W-1:0] lo [NT];
  logic [DATA_W-1:0] hi [NT];
  logic [7:0]        mode_byte;
  logic              tick, split, hi_step, wr_cfg, wr_ctrl;
  logic [DATA_W-1:0] tl0, th0, tl1, th1;

  tmr_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign split   = (cfg_q[0].mode == MD_SPLIT);
  assign hi_step = split & tick & run_q[1];
  assign run_eff = {split | run_q[1], run_q[0]};
  assign wr_cfg  = wr_en_i && (wr_sel_i == SEL_CFG);
  assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign wr_lo   = {wr_en_i && (wr_sel_i == SEL_TL1), wr_en_i && (wr_sel_i == SEL_TL0)};
  assign wr_hi   = {wr_en_i && (wr_sel_i == SEL_TH1), wr_en_i && (wr_sel_i == SEL_TH0)};

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    tmr_pin_sampler u_smp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick),
      .pin_i  (cnt_pin_i[i]),
      .fall_o (ev[i])
    );

    assign en[i]   = run_eff[i] & (~cfg_q[i].gate | gate_pin_i[i]);
    assign step[i] = en[i] & (cfg_q[i].cnt_sel ? ev[i] : tick);

    tmr_unit #(
      .DATA_W    (DATA_W),
      .PRE_W     (PRE_W),
      .HAS_SPLIT (i == 0)
    ) u_unit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (cfg_q[i].mode),
      .step_i    (step[i]),
      .hi_step_i ((i == 0) ? hi_step : 1'b0),
      .wr_lo_i   (wr_lo[i]),
      .wr_hi_i   (wr_hi[i]),
      .wr_data_i (wr_data_i),
      .lo_o      (lo[i]),
      .hi_o      (hi[i]),
      .ovf_o     (ovf[i]),
      .hi_ovf_o  (hi_ovf[i])
    );
  end

  // in split layout flag 1 belongs to the high byte of counter 0
  assign set = {split ? hi_ovf[0] : ovf[1], ovf[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q[0] <= '0;
      cfg_q[1] <= '0;
      run_q    <= '0;
      flag_q   <= '0;
      pulse_q  <= '0;
    end else begin
      pulse_q <= ovf;
      if (wr_cfg) begin
        cfg_q[0] <= tmr_cfg_t'(wr_data_i[3:0]);
        cfg_q[1] <= tmr_cfg_t'(wr_data_i[7:4]);
      end
      if (wr_ctrl) begin
        run_q  <= wr_data_i[1:0];
        flag_q <= wr_data_i[3:2];
      end else begin
        flag_q <= flag_q | set;
      end
    end
  end

  assign mode_byte = {cfg_q[1], cfg_q[0]};
  assign tl0 = lo[0];
  assign th0 = hi[0];
  assign tl1 = lo[1];
  assign th1 = hi[1];

  always_comb begin
    unique case (rd_sel_i)
      SEL_TL0:  rd_data_o = tl0;
      SEL_TL1:  rd_data_o = tl1;
      SEL_TH0:  rd_data_o = th0;
      SEL_TH1:  rd_data_o = th1;
      SEL_CFG:  rd_data_o = DATA_W'(mode_byte);
      SEL_CTRL: rd_data_o = DATA_W'({flag_q, run_q});
      default:  rd_data_o = '0;
    endcase
  end

  assign tf0_o    = flag_q[0];
  assign tf1_o    = flag_q[1];
  assign t0_ovf_o = pulse_q[0];
  assign t1_ovf_o = pulse_q[1];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PRE_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [2:0]        wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] tl0_i,
  input logic [DATA_W-1:0] th0_i,
  input logic [DATA_W-1:0] tl1_i,
  input logic [DATA_W-1:0] th1_i,
  input logic [7:0]        mode_i,
  input logic [1:0]        run_i,
  input logic              t0_ovf_i,
  input logic              tf0_i
);
  logic wr0, wr1;
  assign wr0 = wr_en_i && (wr_sel_i == SEL_TL0 || wr_sel_i == SEL_TH0);
  assign wr1 = wr_en_i && (wr_sel_i == SEL_TL1 || wr_sel_i == SEL_TH1);

  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  assert_top_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1:0] == 2'd0 && !wr0) |=> $stable(tl0_i[DATA_W-1:PRE_W]));

  assert_reload_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1:0] == 2'd2 && !wr0) |=> $stable(th0_i));

  assert_t1_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[5:4] == 2'd3 && !wr1) |=> ($stable(tl1_i) && $stable(th1_i)));

  assert_stopped_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i[0] && mode_i[1:0] != 2'd3 && !wr0) |=> ($stable(tl0_i) && $stable(th0_i)));

  assert_write_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_TL0) |=> (tl0_i == $past(wr_data_i)));

  assert_pulse_flag_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t0_ovf_i && !$past(wr_en_i && wr_sel_i == SEL_CTRL)) |-> tf0_i);
endmodule

bind tmr_pair tmr_pair_chk #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .tl0_i     (tl0),
  .th0_i     (th0),
  .tl1_i     (tl1),
  .th1_i     (th1),
  .mode_i    (mode_byte),
  .run_i     (run_q),
  .t0_ovf_i  (t0_ovf_o),
  .tf0_i     (tf0_o)
);

// File: tb/tmr_pair_test.sv
module tmr_pair_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [1:0] cnt_pin = '0;
  logic [1:0] gate_pin = '0;
  logic       tf0, tf1, p0, p1;

  always #4 clk = ~clk;

  tmr_pair uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .rd_sel_i   (rd_sel),
    .rd_data_o  (rd_data),
    .cnt_pin_i  (cnt_pin),
    .gate_pin_i (gate_pin),
    .tf0_o      (tf0),
    .tf1_o      (tf1),
    .t0_ovf_o   (p0),
    .t1_ovf_o   (p1)
  );

  // reference model, stepped at every rising edge out of reset
  logic [7:0] m_tl [2];
  logic [7:0] m_th [2];
  logic [7:0] m_mode = '0;
  logic [1:0] m_run = '0, m_flag = '0, m_pul = '0, m_samp = '0;
  int         m_pre = 0;
  int         checks = 0, errors = 0;
  bit         done = 1'b0, wd_hit = 1'b0;
  string      tag = "R1";

  initial begin
    m_tl[0] = '0; m_tl[1] = '0; m_th[0] = '0; m_th[1] = '0;
  end

  function automatic void unit_step(input logic [1:0] md, input bit can_split,
                                    input bit st, input bit hst,
                                    inout logic [7:0] lo, inout logic [7:0] hi,
                                    output bit ov, output bit hov);
    ov = 1'b0; hov = 1'b0;
    case (md)
      2'd0: if (st) begin
        if (lo[4:0] == 5'h1f) begin
          lo[4:0] = 5'h00; ov = (hi == 8'hff); hi = hi + 8'd1;
        end else lo[4:0] = lo[4:0] + 5'd1;
      end
      2'd1: if (st) begin
        ov = ({hi, lo} == 16'hffff);
        {hi, lo} = {hi, lo} + 16'd1;
      end
      2'd2: if (st) begin
        if (lo == 8'hff) begin lo = hi; ov = 1'b1; end
        else lo = lo + 8'd1;
      end
      default: if (can_split) begin
        if (st) begin ov = (lo == 8'hff); lo = lo + 8'd1; end
        if (hst) begin hov = (hi == 8'hff); hi = hi + 8'd1; end
      end
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit tick, split, hst, ov0, hov0, ov1, hov1, w;
    bit [1:0] ev, en, st;
    logic [7:0] lo0, hi0, lo1, hi1;
    if (rst_n) begin
      tick = (m_pre == 11);
      m_pre = tick ? 0 : m_pre + 1;
      for (int i = 0; i < 2; i++) begin
        ev[i] = tick && m_samp[i] && !cnt_pin[i];
        if (tick) m_samp[i] = cnt_pin[i];
      end
      split = (m_mode[1:0] == 2'd3);
      en[0] = m_run[0] && (!m_mode[3] || gate_pin[0]);
      en[1] = (split || m_run[1]) && (!m_mode[7] || gate_pin[1]);
      st[0] = en[0] && (m_mode[2] ? ev[0] : tick);
      st[1] = en[1] && (m_mode[6] ? ev[1] : tick);
      hst = split && tick && m_run[1];
      w = wr_en;
      lo0 = m_tl[0]; hi0 = m_th[0]; lo1 = m_tl[1]; hi1 = m_th[1];
      unit_step(m_mode[1:0], 1'b1, st[0], hst, lo0, hi0, ov0, hov0);
      unit_step(m_mode[5:4], 1'b0, st[1], 1'b0, lo1, hi1, ov1, hov1);
      if (split) begin
        if (w && wr_sel == 3'd0) begin lo0 = wr_data; ov0 = 1'b0; end
        if (w && wr_sel == 3'd2) begin hi0 = wr_data; hov0 = 1'b0; end
      end else if (w && (wr_sel == 3'd0 || wr_sel == 3'd2)) begin
        lo0 = (wr_sel == 3'd0) ? wr_data : m_tl[0];
        hi0 = (wr_sel == 3'd2) ? wr_data : m_th[0];
        ov0 = 1'b0;
      end
      if (w && (wr_sel == 3'd1 || wr_sel == 3'd3)) begin
        lo1 = (wr_sel == 3'd1) ? wr_data : m_tl[1];
        hi1 = (wr_sel == 3'd3) ? wr_data : m_th[1];
        ov1 = 1'b0;
      end
      if (w && wr_sel == 3'd5) begin
        m_run = wr_data[1:0]; m_flag = wr_data[3:2];
      end else begin
        m_flag = m_flag | {split ? hov0 : ov1, ov0};
      end
      m_pul = {ov1, ov0};
      if (w && wr_sel == 3'd4) m_mode = wr_data;
      m_tl[0] = lo0; m_th[0] = hi0; m_tl[1] = lo1; m_th[1] = hi1;
    end
  end

  function automatic logic [7:0] exp_reg(input int k);
    case (k)
      0: return m_tl[0];
      1: return m_tl[1];
      2: return m_th[0];
      3: return m_th[1];
      4: return m_mode;
      default: return {4'h0, m_flag, m_run};
    endcase
  endfunction

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // compare one rotating register plus flags and pulses each clock
  int k = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1 rd_sel = 3'(k);
      #1;
      chk($sformatf("reg%0d", k), rd_data, exp_reg(k));
      chk("tf0", {7'd0, tf0}, {7'd0, m_flag[0]});
      chk("tf1", {7'd0, tf1}, {7'd0, m_flag[1]});
      chk("pulse0", {7'd0, p0}, {7'd0, m_pul[0]});
      chk("pulse1", {7'd0, p1}, {7'd0, m_pul[1]});
      k = (k + 1) % 6;
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    fork
      begin : run
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";  idle(20);                        // reset values
        tag = "R12";                                   // select map and read back
        wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h33); wr(3'd3, 8'h44);
        wr(3'd4, 8'h00); wr(3'd5, 8'h0c); idle(4); wr(3'd5, 8'h00);
        tag = "R6";                                    // 16-bit rollover, R2 tick rate
        wr(3'd0, 8'hf0); wr(3'd2, 8'hff); wr(3'd1, 8'hfa); wr(3'd3, 8'hff);
        wr(3'd4, 8'h11); wr(3'd5, 8'h03); idle(12 * 24);
        tag = "R10";                                   // stop and restart
        wr(3'd5, 8'h00); idle(40); wr(3'd5, 8'h03); idle(60);
        tag = "R5";                                    // 13-bit layout
        wr(3'd5, 8'h00); wr(3'd4, 8'h00); wr(3'd0, 8'hfc); wr(3'd2, 8'hff);
        wr(3'd5, 8'h01); idle(12 * 40);
        tag = "R7";                                    // reload layout
        wr(3'd5, 8'h00); wr(3'd4, 8'h22); wr(3'd2, 8'hf8); wr(3'd0, 8'hfd);
        wr(3'd3, 8'h80); wr(3'd1, 8'hfe); wr(3'd5, 8'h03); idle(12 * 30);
        tag = "R3";                                    // counter function
        wr(3'd5, 8'h00); wr(3'd4, 8'h50); wr(3'd1, 8'hfd); wr(3'd3, 8'hff);
        wr(3'd5, 8'h02);
        repeat (8) begin cnt_pin[1] = 1'b1; idle(30); cnt_pin[1] = 1'b0; idle(30); end
        repeat (60) begin @(negedge clk); cnt_pin = ~cnt_pin; end
        tag = "R4";                                    // gate
        wr(3'd5, 8'h00); wr(3'd4, 8'h09); wr(3'd0, 8'hf0); wr(3'd2, 8'hff);
        wr(3'd5, 8'h01); gate_pin[0] = 1'b0; idle(100);
        gate_pin[0] = 1'b1; idle(150); gate_pin[0] = 1'b0; idle(50);
        tag = "R8";                                    // split layout
        wr(3'd5, 8'h00); wr(3'd4, 8'h13); wr(3'd0, 8'hf8); wr(3'd2, 8'hfc);
        wr(3'd1, 8'hf0); wr(3'd3, 8'hff); wr(3'd5, 8'h01); idle(12 * 20);
        wr(3'd5, 8'h03); idle(12 * 20); wr(3'd5, 8'h02); idle(200);
        tag = "R9";                                    // counter 1 hold
        wr(3'd4, 8'h31); wr(3'd5, 8'h03); idle(200);
        tag = "R11";                                   // write collisions
        wr(3'd4, 8'h11); wr(3'd0, 8'hff); wr(3'd2, 8'hff); wr(3'd5, 8'h03);
        for (int i = 0; i < 48; i++) begin
          @(negedge clk);
          wr_en = 1'b1; wr_sel = 3'(i % 4); wr_data = 8'hff;
        end
        for (int i = 0; i < 48; i++) begin
          @(negedge clk);
          wr_en = (i % 2 == 0); wr_sel = (i % 4 == 0) ? 3'd5 : 3'd0;
          wr_data = (i % 4 == 0) ? 8'h03 : 8'hff;
        end
        @(negedge clk); wr_en = 1'b0;
        tag = "R13";                                   // random mix
        for (int i = 0; i < 4000; i++) begin
          @(negedge clk);
          wr_en = ($urandom % 4 == 0);
          wr_sel = 3'($urandom % 6);
          wr_data = 8'($urandom);
          if ($urandom % 8 == 0) cnt_pin = 2'($urandom);
          if ($urandom % 16 == 0) gate_pin = 2'($urandom);
        end
        @(negedge clk); wr_en = 1'b0;
        idle(4);
      end
      begin : watchdog
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    done = 1'b1;
    if (wd_hit) begin
      checks++;
      $display("FAIL watchdog act=timeout exp=finished");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors + (wd_hit ? 1 : 0));
    $finish;
  end
endmodule